// File: doc/BRIEF.md
# DMA Command Staging Registers

This block is a small group of memory-mapped registers through which a host prepares one DMA command for a coprocessor that has a 256 KiB local store. The host first writes four parameter registers: the local-store address, the upper and lower halves of a 64-bit effective address, and a packed word that carries the transfer size and tag. It then writes a command word. That write arms the command, and the block presents every staged field to a downstream DMA request interface as a single-cycle valid pulse.

Each parameter write is checked as it arrives. A value out of range is refused: the register keeps its old content, and an error strobe pulses for one cycle. The pulse leaves the block only while the downstream ready input is high. Until that happens the armed command waits, and the block refuses every further write. When the pulse leaves, all staged parameters return to zero. One bit of the command word (bit 12) is stripped from the command that goes downstream and instead raises a run-start request for the coprocessor in the same cycle.

Reads need no strobe. The read data always shows the register selected by `addr`. Two read-only offsets give fixed status words, one for enqueue status and one for queue status.

Top module: `dma_cmd_stage`

## Requirements
- R1: After reset, `reqValid`, `runStart` and `errStrobe` are low, and the four parameter registers read as zero.
- R2: The local-store address register is at offset 0. A write of a value below 0x40000 is stored. A write of 0x40000 or more is refused, and the register is left unchanged.
- R3: The effective-address registers are at offsets 1 (upper 32 bits) and 2 (lower 32 bits). They accept any value, and `reqEa` carries {upper, lower}.
- R4: The size/tag register is at offset 3, with the size in bits 31:16 and the tag in bits 15:0. A write is refused, and the register left unchanged, when the size is above 16384 or the tag is 32 or more.
- R5: A write to offset 4 arms a command. `reqValid` is then high for exactly one cycle and carries the staged local-store address, effective address, size and tag. It also carries the command word with bit 12 cleared.
- R6: When bit 12 of the command write is set, `runStart` is high in the same cycle as the `reqValid` pulse, and it is low at all other times.
- R7: In the cycle after the `reqValid` pulse, all four parameter registers read as zero.
- R8: While `reqReady` is low, an armed command stays pending and `reqValid` stays low. Every write made while a command is pending is refused.
- R9: `errStrobe` is high for exactly the one cycle after each refused write. A write to any offset other than 0 to 4 is refused.
- R10: A read of offset 5 returns 0x00000001, meaning enqueue successful. A read of offset 6 returns 0x80000000 OR'd with the free-slot count (8), which is 0x80000008. A read of offset 4 or 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Word offset for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the register at `addr` (combinational) |
| reqReady | input | 1 | Downstream is able to accept a request |
| reqValid | output | 1 | One-cycle request pulse |
| reqLsa | output | 18 | Local-store address of the request |
| reqEa | output | 64 | Effective address of the request |
| reqSize | output | 16 | Transfer size in bytes |
| reqTag | output | 5 | Tag group of the request |
| reqCmd | output | 32 | Command word with the start bit cleared |
| runStart | output | 1 | Coprocessor run-start request |
| errStrobe | output | 1 | Refused-write pulse |

## Verification
The bench builds the block with its default parameters. These are a 256 KiB local store (18 address bits), a 16384-byte size limit, 32 tags, start bit 12 and eight free slots. With these values the exact acceptance edges can be driven directly: 0x3FFFF against 0x40000, size 16384 against 16385, and tag 31 against 32. Random traffic toggles `reqReady` against armed commands, so the bench also covers writes that arrive while a command is pending and issues that arrive on the same edge as a write.

// File: rtl/dma_stage_pkg.sv
package dma_stage_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_LSA     = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_EAH     = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_EAL     = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_SIZETAG = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_CMD     = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_CMDSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_QSTAT   = 3'd6;

  localparam logic [31:0] ENQ_OK_CODE = 32'h0000_0001;
  localparam logic [31:0] QEMPTY_FLAG = 32'h8000_0000;

  typedef struct packed {
    logic ldLsa;
    logic ldEah;
    logic ldEal;
    logic ldSizeTag;
    logic arm;
    logic clear;
    logic reject;
  } stageStrobe_t;

endpackage

// File: rtl/dma_stage_ctrl.sv
module dma_stage_ctrl
  import dma_stage_pkg::*;
#(
  parameter int unsigned LS_BYTES  = 262144,
  parameter int unsigned MAX_XFER  = 16384,
  parameter int unsigned TAG_COUNT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              reqReady,
  output stageStrobe_t      strobe,
  output logic              pending,
  output logic              errStrobe
);

  logic pendingQ;
  logic lsaOk;
  logic sizeTagOk;
  logic issue;

  assign lsaOk     = wrData < LS_BYTES;
  assign sizeTagOk = ({16'b0, wrData[31:16]} <= MAX_XFER) &&
                     ({16'b0, wrData[15:0]} < TAG_COUNT);
  assign issue     = pendingQ && reqReady;

  always_comb begin
    strobe       = '0;
    strobe.clear = issue;
    if (wrEn) begin
      if (pendingQ) begin
        strobe.reject = 1'b1;
      end else begin
        unique case (addr)
          OFF_LSA:     if (lsaOk) strobe.ldLsa = 1'b1; else strobe.reject = 1'b1;
          OFF_EAH:     strobe.ldEah = 1'b1;
          OFF_EAL:     strobe.ldEal = 1'b1;
          OFF_SIZETAG: if (sizeTagOk) strobe.ldSizeTag = 1'b1; else strobe.reject = 1'b1;
          OFF_CMD:     strobe.arm = 1'b1;
          default:     strobe.reject = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ  <= 1'b0;
      errStrobe <= 1'b0;
    end else begin
      errStrobe <= strobe.reject;
      if (strobe.arm)  pendingQ <= 1'b1;
      else if (issue)  pendingQ <= 1'b0;
    end
  end

  assign pending = pendingQ;

  AST_ERR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> $past(wrEn)); // R9

  AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pendingQ && !reqReady |=> pendingQ); // R8

  AST_PENDING_REFUSES: assert property (@(posedge clk) disable iff (!rstN)
    pendingQ && wrEn |=> errStrobe); // R8

endmodule

// File: rtl/dma_stage_dp.sv
module dma_stage_dp
  import dma_stage_pkg::*;
#(
  parameter int unsigned LSA_W       = 18,
  parameter int unsigned TAG_W       = 5,
  parameter int unsigned MAX_XFER    = 16384,
  parameter int unsigned START_BIT   = 12,
  parameter int unsigned QUEUE_SPACE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobe_t      strobe,
  input  logic              pending,
  input  logic              reqReady,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              reqValid,
  output logic [LSA_W-1:0]  reqLsa,
  output logic [63:0]       reqEa,
  output logic [15:0]       reqSize,
  output logic [TAG_W-1:0]  reqTag,
  output logic [31:0]       reqCmd,
  output logic              runStart
);

  localparam logic [31:0] START_MASK = 32'd1 << START_BIT;
  localparam int unsigned TAG_PAD    = 16 - TAG_W;

  logic [LSA_W-1:0] lsaQ;
  logic [31:0]      eahQ;
  logic [31:0]      ealQ;
  logic [15:0]      sizeQ;
  logic [TAG_W-1:0] tagQ;
  logic [31:0]      cmdQ;
  logic             startQ;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      lsaQ   <= '0;
      eahQ   <= '0;
      ealQ   <= '0;
      sizeQ  <= '0;
      tagQ   <= '0;
      cmdQ   <= '0;
      startQ <= 1'b0;
    end else begin
      if (strobe.ldLsa) lsaQ <= wrData[LSA_W-1:0];
      if (strobe.ldEah) eahQ <= wrData;
      if (strobe.ldEal) ealQ <= wrData;
      if (strobe.ldSizeTag) begin
        sizeQ <= wrData[31:16];
        tagQ  <= wrData[TAG_W-1:0];
      end
      if (strobe.arm) begin
        cmdQ   <= wrData & ~START_MASK;
        startQ <= wrData[START_BIT];
      end
    end
  end

  assign reqValid = pending && reqReady;
  assign reqLsa   = lsaQ;
  assign reqEa    = {eahQ, ealQ};
  assign reqSize  = sizeQ;
  assign reqTag   = tagQ;
  assign reqCmd   = cmdQ;
  assign runStart = reqValid && startQ;

  always_comb begin
    unique case (addr)
      OFF_LSA:     rdData = {{(32-LSA_W){1'b0}}, lsaQ};
      OFF_EAH:     rdData = eahQ;
      OFF_EAL:     rdData = ealQ;
      OFF_SIZETAG: rdData = {sizeQ, {TAG_PAD{1'b0}}, tagQ};
      OFF_CMDSTAT: rdData = ENQ_OK_CODE;
      OFF_QSTAT:   rdData = QEMPTY_FLAG | QUEUE_SPACE;
      default:     rdData = '0;
    endcase
  end

  AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    {16'b0, sizeQ} <= MAX_XFER); // R4

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reject && !strobe.clear |=> $stable(lsaQ) && $stable(sizeQ) && $stable(tagQ)); // R2

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid); // R5

  AST_CLEAR_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> lsaQ == '0 && eahQ == '0 && ealQ == '0 && sizeQ == '0 && tagQ == '0); // R7

  AST_CMD_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !reqCmd[START_BIT]); // R5

endmodule

// File: rtl/dma_cmd_stage.sv
module dma_cmd_stage
  import dma_stage_pkg::*;
#(
  parameter int unsigned LS_BYTES    = 262144,
  parameter int unsigned MAX_XFER    = 16384,
  parameter int unsigned TAG_COUNT   = 32,
  parameter int unsigned START_BIT   = 12,
  parameter int unsigned QUEUE_SPACE = 8,
  parameter int unsigned LSA_W       = $clog2(LS_BYTES),
  parameter int unsigned TAG_W       = $clog2(TAG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              reqReady,
  output logic              reqValid,
  output logic [LSA_W-1:0]  reqLsa,
  output logic [63:0]       reqEa,
  output logic [15:0]       reqSize,
  output logic [TAG_W-1:0]  reqTag,
  output logic [31:0]       reqCmd,
  output logic              runStart,
  output logic              errStrobe
);

  stageStrobe_t strobe;
  logic         pending;

  dma_stage_ctrl #(
    .LS_BYTES (LS_BYTES),
    .MAX_XFER (MAX_XFER),
    .TAG_COUNT(TAG_COUNT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .reqReady (reqReady),
    .strobe   (strobe),
    .pending  (pending),
    .errStrobe(errStrobe)
  );

  dma_stage_dp #(
    .LSA_W      (LSA_W),
    .TAG_W      (TAG_W),
    .MAX_XFER   (MAX_XFER),
    .START_BIT  (START_BIT),
    .QUEUE_SPACE(QUEUE_SPACE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pending (pending),
    .reqReady(reqReady),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .reqValid(reqValid),
    .reqLsa  (reqLsa),
    .reqEa   (reqEa),
    .reqSize (reqSize),
    .reqTag  (reqTag),
    .reqCmd  (reqCmd),
    .runStart(runStart)
  );

  AST_START_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    runStart |-> reqValid); // R6

endmodule

// File: tb/dma_cmd_stage_tb.sv
`timescale 1ns/1ps
module dma_cmd_stage_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        reqReady = 1'b0;
  logic        reqValid;
  logic [17:0] reqLsa;
  logic [63:0] reqEa;
  logic [15:0] reqSize;
  logic [4:0]  reqTag;
  logic [31:0] reqCmd;
  logic        runStart;
  logic        errStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [17:0] mLsa;
  logic [31:0] mEah, mEal, mCmd;
  logic [15:0] mSize;
  logic [4:0]  mTag;
  logic        mStart, mPend, mRej;

  always #4 clk = ~clk;

  dma_cmd_stage u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .reqReady(reqReady), .reqValid(reqValid), .reqLsa(reqLsa),
    .reqEa(reqEa), .reqSize(reqSize), .reqTag(reqTag), .reqCmd(reqCmd),
    .runStart(runStart), .errStrobe(errStrobe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {14'b0, mLsa};
      3'd1: return mEah;
      3'd2: return mEal;
      3'd3: return {mSize, 11'b0, mTag};
      3'd5: return 32'h0000_0001;
      3'd6: return 32'h8000_0008;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit accepts(input logic [2:0] a, input logic [31:0] d);
    case (a)
      3'd0: return d < 32'h40000;
      3'd1, 3'd2, 3'd4: return 1'b1;
      3'd3: return (d[31:16] <= 16'd16384) && (d[15:0] < 16'd32);
      default: return 1'b0;
    endcase
  endfunction

  // one write, ends on the following negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(req, rdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 reqValid", reqValid, 0);
    chk("R1 runStart", runStart, 0);
    chk("R1 errStrobe", errStrobe, 0);
    for (int i = 0; i < 4; i++) rdChk("R1 param read", 3'(i), 0);

    // R10 status reads
    rdChk("R10 cmd status", 3'd5, 32'h1);
    rdChk("R10 queue status", 3'd6, 32'h8000_0008);
    rdChk("R10 offset 7", 3'd7, 32'h0);
    rdChk("R10 offset 4", 3'd4, 32'h0);

    // R2 local-store boundary
    wr(3'd0, 32'h3FFFF);
    chk("R2 accept err", errStrobe, 0);
    rdChk("R2 accept read", 3'd0, 32'h3FFFF);
    wr(3'd0, 32'h40000);
    chk("R9 reject err", errStrobe, 1);
    rdChk("R2 reject keeps", 3'd0, 32'h3FFFF);
    @(negedge clk);
    chk("R9 err one cycle", errStrobe, 0);

    // R3 effective address
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd2, 32'h1234_5678);
    rdChk("R3 eah", 3'd1, 32'hDEAD_BEEF);
    rdChk("R3 eal", 3'd2, 32'h1234_5678);

    // R4 size/tag limits
    wr(3'd3, {16'd16384, 16'd31});
    chk("R4 accept err", errStrobe, 0);
    rdChk("R4 accept read", 3'd3, {16'd16384, 16'd31});
    wr(3'd3, {16'd16385, 16'd1});
    chk("R4 size reject err", errStrobe, 1);
    rdChk("R4 size reject keeps", 3'd3, {16'd16384, 16'd31});
    wr(3'd3, {16'd16, 16'd32});
    chk("R4 tag reject err", errStrobe, 1);
    rdChk("R4 tag reject keeps", 3'd3, {16'd16384, 16'd31});

    // R5/R6 issue with start bit (bit 12)
    reqReady = 1'b1;
    wr(3'd4, 32'h0000_1042);
    chk("R5 valid", reqValid, 1);
    chk("R5 lsa", reqLsa, 18'h3FFFF);
    chk("R3 ea", reqEa, 64'hDEAD_BEEF_1234_5678);
    chk("R5 size", reqSize, 16384);
    chk("R5 tag", reqTag, 31);
    chk("R5 cmd masked", reqCmd, 32'h42);
    chk("R6 runStart", runStart, 1);
    @(negedge clk);
    chk("R5 single pulse", reqValid, 0);
    chk("R6 runStart low", runStart, 0);
    for (int i = 0; i < 4; i++) rdChk("R7 cleared", 3'(i), 0);

    // R8 hold-off
    reqReady = 1'b0;
    wr(3'd0, 32'h100);
    wr(3'd4, 32'h20);
    chk("R8 held", reqValid, 0);
    repeat (3) @(negedge clk);
    chk("R8 still held", reqValid, 0);
    wr(3'd2, 32'h5);
    chk("R8 pending write refused", errStrobe, 1);
    reqReady = 1'b1; #1;
    chk("R8 released valid", reqValid, 1);
    chk("R8 lsa", reqLsa, 18'h100);
    chk("R8 ea untouched", reqEa, 64'h0);
    chk("R6 no start", runStart, 0);
    @(negedge clk);
    chk("R5 pulse ends", reqValid, 0);

    // R9 unknown offset
    wr(3'd7, 32'h1);
    chk("R9 unknown offset", errStrobe, 1);
    wr(3'd5, 32'h1);
    chk("R9 status write", errStrobe, 1);

    // random phase, model from requirements
    mLsa = '0; mEah = '0; mEal = '0; mSize = '0; mTag = '0;
    mCmd = '0; mStart = 1'b0; mPend = 1'b0; mRej = 1'b0;
    @(negedge clk);
    for (int n = 0; n < 2000; n++) begin
      logic [2:0]  a;
      logic [31:0] d;
      logic        w;
      logic        issue;
      chk("R9 random err", errStrobe, mRej);
      a = 3'($urandom_range(0, 7));
      d = $urandom;
      case ($urandom_range(0, 3))
        0: d = d & 32'h7FFFF;
        1: d = {16'($urandom_range(16380, 16390)), 16'($urandom_range(28, 34))};
        default: ;
      endcase
      w = ($urandom_range(0, 3) != 0);
      reqReady = ($urandom_range(0, 3) != 0);
      wrEn = w; addr = a; wrData = d;
      #1;
      issue = mPend && reqReady;
      chk("R8 random valid", reqValid, issue);
      chk("R6 random start", runStart, issue && mStart);
      chk("R10 random read", rdData, expRead(a));
      if (issue) begin
        chk("R5 random lsa", reqLsa, mLsa);
        chk("R3 random ea", reqEa, {mEah, mEal});
        chk("R5 random size/tag", {reqSize, reqTag}, {mSize, mTag});
        chk("R5 random cmd", reqCmd, mCmd);
      end
      mRej = w && (mPend || !accepts(a, d));
      if (issue) begin
        mLsa = '0; mEah = '0; mEal = '0; mSize = '0; mTag = '0;
        mCmd = '0; mStart = 1'b0; mPend = 1'b0;
      end else if (w && !mRej) begin
        case (a)
          3'd0: mLsa = d[17:0];
          3'd1: mEah = d;
          3'd2: mEal = d;
          3'd3: begin mSize = d[31:16]; mTag = d[4:0]; end
          3'd4: begin mCmd = d & ~32'h1000; mStart = d[12]; mPend = 1'b1; end
          default: ;
        endcase
      end
      @(negedge clk);
      wrEn = 1'b0;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule